// File: doc/BRIEF.md
# Reversible Register ALU

This block is the execute stage of a processor whose every data operation can be undone. It holds sixteen 16-bit registers. It applies one operation per strobe: add, subtract, XOR, rotate left, rotate right, or an exchange of two registers. The second operand is either a register or a 16-bit immediate.

A direction input selects forward or inverse execution. In the inverse direction, add becomes subtract and rotate left becomes rotate right, and the reverse holds for both pairs. XOR and exchange are unchanged, because each is its own inverse. Running an instruction forward and then inverse with the same fields restores the register file exactly.

Adding or subtracting a register to itself cannot be undone, so the block reports that case as illegal and writes nothing. Two combinational read ports expose the registers named by the index inputs. A sequencer uses them to evaluate branch conditions, and the memory exchange path uses them to form and swap data.

Top module: `rev_alu_core`

## Requirements
- R1: After reset, every register reads as zero.
- R2: Registers change only on a rising clock edge where `exec_i` is high; with `exec_i` low every register holds its value.
- R3: In forward mode, opcode 0x01 writes rd+rs to rd and opcode 0x02 writes rd-rs to rd (16-bit wraparound), when the indices differ.
- R4: Opcodes 0x03 (register) and 0x23 (immediate) write rd XOR operand to rd, identically in either direction.
- R5: In forward mode, opcode 0x04 rotates rd left and 0x05 rotates rd right by the low 4 bits of rs (amount modulo 16).
- R6: Opcodes 0x21..0x25 act as 0x01..0x05 with `imm_i` as the operand; `rs_idx_i` is ignored and never makes the instruction illegal.
- R7: Opcode 0x08 exchanges rd and rs in one edge, in either direction.
- R8: With `inverse_i` high, the add and subtract opcodes (register and immediate) perform the other operation, and the rotate left and rotate right opcodes perform the other rotation, so an inverse step undoes the matching forward step.
- R9: Opcode 0x01 or 0x02 with rd index equal to rs index drives `illegal_o` high combinationally, in either direction, and leaves every register unchanged.
- R10: Opcode 0x00 and every opcode not listed above (e.g. 0x06, 0x0F, 0x29, 0x36, 0x3F) leave all registers unchanged and keep `illegal_o` low.
- R11: `rd_data_o` and `rs_data_o` show the registers selected by `rd_idx_i` and `rs_idx_i` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe; commits the operation at the clock edge |
| inverse_i | input | 1 | 1 selects inverse execution |
| opcode_i | input | 6 | Decoded operation code |
| rd_idx_i | input | 4 | Destination register index |
| rs_idx_i | input | 4 | Source register index |
| imm_i | input | 16 | Immediate operand |
| rd_data_o | output | 16 | Contents of register rd_idx_i |
| rs_data_o | output | 16 | Contents of register rs_idx_i |
| illegal_o | output | 1 | Current instruction is irreversible (self add/subtract) |

## Verification
A wrong register value shows on a read port in the same cycle that its index is selected, so every effect can be seen one edge after the strobe. Stray writes, such as a write on an idle cycle, a write to the wrong index, a wrong operation for the direction, or a write on an illegal instruction, corrupt a register that stays wrong until it is overwritten. Forward and inverse pairs make such faults more visible, because a faulty inverse leaves a nonzero difference from the value loaded before the pair.

// File: rtl/rev_alu_pkg.sv
package rev_alu_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_NOP  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADD  = 6'h01;
  localparam logic [OPC_W-1:0] OPC_SUB  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_XOR  = 6'h03;
  localparam logic [OPC_W-1:0] OPC_ROL  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_ROR  = 6'h05;
  localparam logic [OPC_W-1:0] OPC_SWP  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'h21;
  localparam logic [OPC_W-1:0] OPC_SUBI = 6'h22;
  localparam logic [OPC_W-1:0] OPC_XORI = 6'h23;
  localparam logic [OPC_W-1:0] OPC_ROLI = 6'h24;
  localparam logic [OPC_W-1:0] OPC_RORI = 6'h25;

  typedef enum logic [2:0] {
    K_NONE, K_ADD, K_SUB, K_XOR, K_ROL, K_ROR, K_SWP
  } op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    logic     use_imm;
    logic     illegal;
  } dec_t;
endpackage

// File: rtl/rev_op_decode.sv
module rev_op_decode
  import rev_alu_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             inverse_i,
  input  logic [AW-1:0]    rd_idx_i,
  input  logic [AW-1:0]    rs_idx_i,
  output dec_t             dec_o
);
  op_kind_e base_kind;
  logic     imm_form;
  logic     self_arith;

  always_comb begin
    base_kind = K_NONE;
    imm_form  = 1'b0;
    unique case (opcode_i)
      OPC_ADD:  base_kind = K_ADD;
      OPC_SUB:  base_kind = K_SUB;
      OPC_XOR:  base_kind = K_XOR;
      OPC_ROL:  base_kind = K_ROL;
      OPC_ROR:  base_kind = K_ROR;
      OPC_SWP:  base_kind = K_SWP;
      OPC_ADDI: begin base_kind = K_ADD; imm_form = 1'b1; end
      OPC_SUBI: begin base_kind = K_SUB; imm_form = 1'b1; end
      OPC_XORI: begin base_kind = K_XOR; imm_form = 1'b1; end
      OPC_ROLI: begin base_kind = K_ROL; imm_form = 1'b1; end
      OPC_RORI: begin base_kind = K_ROR; imm_form = 1'b1; end
      default:  base_kind = K_NONE;
    endcase
  end

  // only register-form add/sub with a shared index destroys information
  assign self_arith = ((opcode_i == OPC_ADD) || (opcode_i == OPC_SUB)) &&
                      (rd_idx_i == rs_idx_i);

  always_comb begin
    dec_o.use_imm = imm_form;
    dec_o.illegal = self_arith;
    dec_o.kind    = base_kind;
    if (inverse_i) begin
      unique case (base_kind)
        K_ADD:   dec_o.kind = K_SUB;
        K_SUB:   dec_o.kind = K_ADD;
        K_ROL:   dec_o.kind = K_ROR;
        K_ROR:   dec_o.kind = K_ROL;
        default: dec_o.kind = base_kind;
      endcase
    end
    if (self_arith) dec_o.kind = K_NONE;
  end
endmodule

// File: rtl/rev_exec_unit.sv
module rev_exec_unit
  import rev_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_kind_e          kind_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int SHW = $clog2(DATA_W);

  logic [SHW-1:0]      amt;
  logic [2*DATA_W-1:0] dbl;
  logic [2*DATA_W-1:0] rol_w;
  logic [2*DATA_W-1:0] ror_w;

  assign amt   = b_i[SHW-1:0];
  assign dbl   = {a_i, a_i};
  assign rol_w = dbl << amt;
  assign ror_w = dbl >> amt;

  always_comb begin
    unique case (kind_i)
      K_ADD:   res_o = a_i + b_i;
      K_SUB:   res_o = a_i - b_i;
      K_XOR:   res_o = a_i ^ b_i;
      K_ROL:   res_o = rol_w[2*DATA_W-1:DATA_W];
      K_ROR:   res_o = ror_w[DATA_W-1:0];
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/rev_regfile.sv
module rev_regfile #(
  parameter int DATA_W = 16,
  parameter int REG_N  = 16,
  localparam int AW    = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     ra_addr_i,
  input  logic [AW-1:0]     rb_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              wa_en_i,
  input  logic [AW-1:0]     wa_addr_i,
  input  logic [DATA_W-1:0] wa_data_i,
  input  logic              wb_en_i,
  input  logic [AW-1:0]     wb_addr_i,
  input  logic [DATA_W-1:0] wb_data_i
);
  logic [DATA_W-1:0] rf [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (wa_en_i && (wa_addr_i == AW'(g))) begin
        q <= wa_data_i;
      end else if (wb_en_i && (wb_addr_i == AW'(g))) begin
        q <= wb_data_i;
      end
    end
    assign rf[g] = q;
  end

  assign ra_data_o = rf[ra_addr_i];
  assign rb_data_o = rf[rb_addr_i];
endmodule

// File: rtl/rev_alu_core.sv
module rev_alu_core
  import rev_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_N  = 16,
  localparam int AW    = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic              inverse_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [AW-1:0]     rd_idx_i,
  input  logic [AW-1:0]     rs_idx_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] rs_data_o,
  output logic              illegal_o
);
  dec_t              dec;
  logic [DATA_W-1:0] rd_val, rs_val, operand, result;
  logic              wa_en, wb_en;
  logic [DATA_W-1:0] wa_data;

  rev_op_decode #(.AW(AW)) i_decode (
    .opcode_i  (opcode_i),
    .inverse_i (inverse_i),
    .rd_idx_i  (rd_idx_i),
    .rs_idx_i  (rs_idx_i),
    .dec_o     (dec)
  );

  assign operand = dec.use_imm ? imm_i : rs_val;

  rev_exec_unit #(.DATA_W(DATA_W)) i_exec (
    .kind_i (dec.kind),
    .a_i    (rd_val),
    .b_i    (operand),
    .res_o  (result)
  );

  // swap: port A loads rd from rs, port B loads rs from rd
  assign wa_en   = exec_i && (dec.kind != K_NONE);
  assign wb_en   = exec_i && (dec.kind == K_SWP);
  assign wa_data = (dec.kind == K_SWP) ? rs_val : result;

  rev_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_addr_i (rd_idx_i),
    .rb_addr_i (rs_idx_i),
    .ra_data_o (rd_val),
    .rb_data_o (rs_val),
    .wa_en_i   (wa_en),
    .wa_addr_i (rd_idx_i),
    .wa_data_i (wa_data),
    .wb_en_i   (wb_en),
    .wb_addr_i (rs_idx_i),
    .wb_data_i (rd_val)
  );

  assign rd_data_o = rd_val;
  assign rs_data_o = rs_val;
  assign illegal_o = dec.illegal;
endmodule

// File: rtl/rev_alu_checker.sv
module rev_alu_checker #(
  parameter int DATA_W = 16,
  parameter int AW     = 4,
  parameter int OPC_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic              inverse_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [AW-1:0]     rd_idx_i,
  input logic [AW-1:0]     rs_idx_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [DATA_W-1:0] rs_data_o,
  input logic              illegal_o
);
  logic idx_same;
  assign idx_same = (rd_idx_i == rs_idx_i);

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> (!($stable(rd_idx_i) && $stable(rs_idx_i)) ||
                 ($stable(rd_data_o) && $stable(rs_data_o))));

  assert_add_fwd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !inverse_i && opcode_i == OPC_W'(8'h01) && !idx_same) |=>
    (!($stable(rd_idx_i) && $stable(rs_idx_i)) ||
     rd_data_o == DATA_W'($past(rd_data_o) + $past(rs_data_o))));

  assert_xor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opcode_i == OPC_W'(8'h03) && !idx_same) |=>
    (!($stable(rd_idx_i) && $stable(rs_idx_i)) ||
     rd_data_o == ($past(rd_data_o) ^ $past(rs_data_o))));

  assert_swap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opcode_i == OPC_W'(8'h08)) |=>
    (!($stable(rd_idx_i) && $stable(rs_idx_i)) ||
     (rd_data_o == $past(rs_data_o) && rs_data_o == $past(rd_data_o))));

  assert_illegal_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && illegal_o) |=>
    (!$stable(rd_idx_i) || $stable(rd_data_o)));

  assert_illegal_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (idx_same &&
                   (opcode_i == OPC_W'(8'h01) || opcode_i == OPC_W'(8'h02))));
endmodule

bind rev_alu_core rev_alu_checker #(
  .DATA_W (DATA_W),
  .AW     (AW),
  .OPC_W  (rev_alu_pkg::OPC_W)
) i_rev_alu_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .exec_i    (exec_i),
  .inverse_i (inverse_i),
  .opcode_i  (opcode_i),
  .rd_idx_i  (rd_idx_i),
  .rs_idx_i  (rs_idx_i),
  .rd_data_o (rd_data_o),
  .rs_data_o (rs_data_o),
  .illegal_o (illegal_o)
);

// File: tb/test_rev_alu_core.sv
`timescale 1ns/1ps
module test_rev_alu_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exec_i = 1'b0;
  logic        inverse_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [3:0]  rd_idx_i = '0;
  logic [3:0]  rs_idx_i = '0;
  logic [15:0] imm_i = '0;
  logic [15:0] rd_data_o, rs_data_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rev_alu_core i_rev_alu_core (
    .clk_i(clk), .rst_ni(rst_ni), .exec_i(exec_i), .inverse_i(inverse_i),
    .opcode_i(opcode_i), .rd_idx_i(rd_idx_i), .rs_idx_i(rs_idx_i),
    .imm_i(imm_i), .rd_data_o(rd_data_o), .rs_data_o(rs_data_o),
    .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [5:0] op, input logic [3:0] rd, input logic [3:0] rs,
                        input logic [15:0] imm, input logic inv);
    @(negedge clk);
    opcode_i = op; rd_idx_i = rd; rs_idx_i = rs; imm_i = imm; inverse_i = inv; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] idx, input logic [15:0] exp);
    rd_idx_i = idx;
    #1;
    chk(req, rd_data_o, exp);
  endtask

  task automatic load_reg(input logic [3:0] idx, input logic [15:0] val);
    logic [15:0] cur;
    rd_idx_i = idx;
    #1;
    cur = rd_data_o;
    run_op(6'h23, idx, 4'd0, cur ^ val, 1'b0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) expect_reg("R1 reset zero", 4'(i), 16'h0000);
  endtask

  task automatic t_load_xor;
    load_reg(4'd1, 16'h1234);
    expect_reg("R4 xori load", 4'd1, 16'h1234);
    load_reg(4'd2, 16'h0F0F);
    expect_reg("R6 xori load", 4'd2, 16'h0F0F);
    run_op(6'h03, 4'd1, 4'd2, 16'h0, 1'b0);
    expect_reg("R4 xor fwd", 4'd1, 16'h1D3B);
    run_op(6'h03, 4'd1, 4'd2, 16'h0, 1'b1);
    expect_reg("R4 xor inverse", 4'd1, 16'h1234);
  endtask

  task automatic t_add_sub;
    run_op(6'h01, 4'd1, 4'd2, 16'h0, 1'b0);
    expect_reg("R3 add", 4'd1, 16'h2143);
    run_op(6'h02, 4'd1, 4'd2, 16'h0, 1'b0);
    expect_reg("R3 sub", 4'd1, 16'h1234);
    run_op(6'h02, 4'd1, 4'd2, 16'h0, 1'b0);
    expect_reg("R3 sub again", 4'd1, 16'h0325);
    run_op(6'h01, 4'd1, 4'd2, 16'h0, 1'b0);
    expect_reg("R3 add back", 4'd1, 16'h1234);
  endtask

  task automatic t_rotate;
    load_reg(4'd3, 16'h0014);  // amount 20 -> 4 mod 16
    run_op(6'h04, 4'd1, 4'd3, 16'h0, 1'b0);
    expect_reg("R5 rol mod16", 4'd1, 16'h2341);
    run_op(6'h05, 4'd1, 4'd3, 16'h0, 1'b0);
    expect_reg("R5 ror back", 4'd1, 16'h1234);
    run_op(6'h05, 4'd1, 4'd3, 16'h0, 1'b0);
    expect_reg("R5 ror", 4'd1, 16'h4123);
    run_op(6'h04, 4'd1, 4'd3, 16'h0, 1'b0);
    expect_reg("R5 rol back", 4'd1, 16'h1234);
  endtask

  task automatic t_imm;
    run_op(6'h21, 4'd2, 4'd2, 16'hFFFF, 1'b0);  // rs==rd must not matter
    expect_reg("R6 addi wrap", 4'd2, 16'h0F0E);
    run_op(6'h21, 4'd2, 4'd9, 16'h0001, 1'b0);
    expect_reg("R6 addi", 4'd2, 16'h0F0F);
    run_op(6'h22, 4'd2, 4'd2, 16'h000F, 1'b0);
    expect_reg("R6 subi", 4'd2, 16'h0F00);
    run_op(6'h22, 4'd2, 4'd0, 16'h000F, 1'b1);
    expect_reg("R8 subi inverse", 4'd2, 16'h0F0F);
    run_op(6'h24, 4'd1, 4'd1, 16'h0008, 1'b0);
    expect_reg("R6 roli", 4'd1, 16'h3412);
    run_op(6'h25, 4'd1, 4'd0, 16'h0004, 1'b0);
    expect_reg("R6 rori", 4'd1, 16'h2341);
    run_op(6'h25, 4'd1, 4'd0, 16'h0004, 1'b1);
    expect_reg("R8 rori inverse", 4'd1, 16'h3412);
    run_op(6'h24, 4'd1, 4'd0, 16'h0008, 1'b1);
    expect_reg("R8 roli inverse", 4'd1, 16'h1234);
  endtask

  task automatic t_inverse;
    run_op(6'h01, 4'd1, 4'd2, 16'h0, 1'b1);
    expect_reg("R8 add inverse", 4'd1, 16'h0325);
    run_op(6'h02, 4'd1, 4'd2, 16'h0, 1'b1);
    expect_reg("R8 sub inverse", 4'd1, 16'h1234);
    run_op(6'h04, 4'd1, 4'd3, 16'h0, 1'b1);
    expect_reg("R8 rol inverse", 4'd1, 16'h4123);
    run_op(6'h05, 4'd1, 4'd3, 16'h0, 1'b1);
    expect_reg("R8 ror inverse", 4'd1, 16'h1234);
  endtask

  task automatic t_swap;
    run_op(6'h08, 4'd1, 4'd2, 16'h0, 1'b0);
    expect_reg("R7 swap rd", 4'd1, 16'h0F0F);
    expect_reg("R7 swap rs", 4'd2, 16'h1234);
    run_op(6'h08, 4'd1, 4'd2, 16'h0, 1'b1);
    expect_reg("R7 swap inverse rd", 4'd1, 16'h1234);
    expect_reg("R7 swap inverse rs", 4'd2, 16'h0F0F);
  endtask

  task automatic t_illegal;
    @(negedge clk);
    opcode_i = 6'h01; rd_idx_i = 4'd1; rs_idx_i = 4'd1; inverse_i = 1'b0;
    #1; chk("R9 illegal add flag", 16'(illegal_o), 16'h0001);
    run_op(6'h01, 4'd1, 4'd1, 16'h0, 1'b0);
    expect_reg("R9 illegal add hold", 4'd1, 16'h1234);
    opcode_i = 6'h02; rd_idx_i = 4'd2; rs_idx_i = 4'd2; inverse_i = 1'b1;
    #1; chk("R9 illegal sub inv flag", 16'(illegal_o), 16'h0001);
    run_op(6'h02, 4'd2, 4'd2, 16'h0, 1'b1);
    expect_reg("R9 illegal sub hold", 4'd2, 16'h0F0F);
    opcode_i = 6'h21; rd_idx_i = 4'd2; rs_idx_i = 4'd2; inverse_i = 1'b0;
    #1; chk("R6 addi same idx legal", 16'(illegal_o), 16'h0000);
  endtask

  task automatic t_nop;
    logic [5:0] ops [6] = '{6'h00, 6'h06, 6'h0F, 6'h29, 6'h36, 6'h3F};
    for (int i = 0; i < 6; i++) begin
      opcode_i = ops[i]; rd_idx_i = 4'd1; rs_idx_i = 4'd2;
      #1; chk("R10 no illegal flag", 16'(illegal_o), 16'h0000);
      run_op(ops[i], 4'd1, 4'd2, 16'hFFFF, 1'(i % 2));
      expect_reg("R10 rd unchanged", 4'd1, 16'h1234);
      expect_reg("R10 rs unchanged", 4'd2, 16'h0F0F);
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    opcode_i = 6'h01; rd_idx_i = 4'd1; rs_idx_i = 4'd2; imm_i = '0; inverse_i = 1'b0;
    exec_i = 1'b0;
    repeat (3) @(negedge clk);
    expect_reg("R2 idle hold", 4'd1, 16'h1234);
    run_op(6'h08, 4'd1, 4'd2, 16'h0, 1'b0);
    run_op(6'h08, 4'd1, 4'd2, 16'h0, 1'b0);
    expect_reg("R2 single write per strobe", 4'd1, 16'h1234);
  endtask

  task automatic t_read;
    rd_idx_i = 4'd3; rs_idx_i = 4'd2;
    #1;
    chk("R11 rd port", rd_data_o, 16'h0014);
    chk("R11 rs port", rs_data_o, 16'h0F0F);
    rs_idx_i = 4'd1;
    #1;
    chk("R11 rs port switch", rs_data_o, 16'h1234);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    t_reset;
    t_load_xor;
    t_add_sub;
    t_rotate;
    t_imm;
    t_inverse;
    t_swap;
    t_illegal;
    t_nop;
    t_idle;
    t_read;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule